// File: doc/BRIEF.md
# CMOS Clock Register Front End

This block sits between a byte-wide host register port and an external calendar counter. It presents the counter's fields as the familiar CMOS clock register map. A host issues single-cycle read or write strobes with an 8-bit index. The block then routes the access to one of four places: the ten calendar fields, four control registers, a version byte port, or an external nonvolatile store.

The calendar fields can be seen in two forms. When the data-mode bit of control register B is clear, reads return packed BCD and writes are taken as BCD. When the bit is set, values pass through in binary. Control register C has three roles:
- It latches an update flag on every calendar tick and clears it when read.
- On every read it reports two active-low card status inputs.
- Writes to it raise a one-cycle log-clear pulse, or toggle a keyboard LED state bit together with a one-cycle command pulse.

Calendar writes are always forwarded to the counter. A separate save qualifier marks the seconds, minutes and hours writes whose values are legal and may therefore be kept in persistent storage.

Top module: `cmos_reg_if`

## Requirements
- R1: After reset, reads return 0x26 for register A (index 10), 0x02 for B (11) and 0x80 for D (13). Register C (12) reads with its LED bit (bit 6) and update flag (bit 4) both clear.
- R2: A read of index 0..9 returns the calendar field `cal_now[8*i +: 8]`. The value is converted from binary to packed BCD when bit 2 of register B is clear, and passed unchanged when that bit is set.
- R3: A write to index 0..9 pulses `cal_wr` in the same cycle, with `cal_sel` equal to the index. `cal_wdata` carries the written byte, converted from BCD (high nibble × 10 + low nibble) when B bit 2 is clear and passed unchanged otherwise.
- R4: `tm_save` is raised with `cal_wr` only for index 0 (seconds, value ≤ 59), index 2 (minutes, ≤ 59) and index 4 (hours, ≤ 23). The limit is applied to the binary value.
- R5: A write to register B stores bit 2 of the written byte and ORs in 0x02. All other written bits are dropped.
- R6: A `tick` sets the update flag (C bit 4). A read of C returns the flag and clears it for later cycles. If a read of C and a tick fall in the same cycle, the read returns the flag as 1 and the flag stays set.
- R7: A read of C returns bit 3 = NOT `card_det_n` and bit 2 = NOT `wp_n`, sampled in the read cycle.
- R8: A write to C with bit 7 set drives `clr_log` high for exactly the one cycle after the write.
- R9: A write to C whose bit 6 differs from the stored LED bit toggles that bit and drives `led_cmd` high for the one cycle after the write. If bit 6 equals the stored bit, the LED bit and `led_cmd` are left unchanged.
- R10: Indices 0xF0..0xFF read `ver_byte`, with `ver_sel` equal to the index's low nibble. Writes to these indices raise no strobe and change no register.
- R11: Indices 14..0xEF are forwarded to storage. `st_rd` or `st_wr` follows the strobe in the same cycle, `st_addr` = index + 2, a read returns `st_rdata`, and `st_wdata` = the written byte.
- R12: Registers A and D store the whole written byte and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| idx | input | 8 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current index (combinational) |
| tick | input | 1 | Calendar advanced this cycle |
| card_det_n | input | 1 | Card present, active low |
| wp_n | input | 1 | Write protect, active low |
| cal_now | input | 80 | Ten binary calendar fields, field i in bits 8i+7..8i |
| cal_wr | output | 1 | Calendar field load strobe |
| cal_sel | output | 4 | Calendar field selected |
| cal_wdata | output | 8 | Binary value to load |
| tm_save | output | 1 | Write is an in-range seconds/minutes/hours value to persist |
| st_rd | output | 1 | Storage read strobe |
| st_wr | output | 1 | Storage write strobe |
| st_addr | output | 8 | Storage address (index + 2) |
| st_wdata | output | 8 | Storage write data |
| st_rdata | input | 8 | Storage read data |
| ver_sel | output | 4 | Version byte selector |
| ver_byte | input | 8 | Version byte for `ver_sel` |
| clr_log | output | 1 | One-cycle log clear pulse |
| led_cmd | output | 1 | One-cycle LED command pulse |

## Verification
The bench builds the block with its default parameters: index offset 2, version window starting at 0xF0, and the stated init bytes for A, B and D. With these values the bench can reach both window edges on every access kind: 13/14 for the control and storage split, 0xEF/0xF0 for the version window, and 9/10 for the calendar and control split. The bench writes through register B to switch between BCD and binary mode. It drives range limits one value either side for seconds and hours, and places a tick together with a C read in the same cycle.

// File: rtl/cmos_reg_pkg.sv
package cmos_reg_pkg;

    localparam int DW        = 8;
    localparam int IW        = 8;
    localparam int N_CAL     = 10;
    localparam int N_CTRL    = 4;
    localparam int CTRL_BASE = N_CAL;
    localparam int CTRL_END  = N_CAL + N_CTRL;
    localparam int SEL_W     = $clog2(N_CAL);

    localparam int B_MODE_BIT = 2;
    localparam int C_CLR_BIT  = 7;
    localparam int C_LED_BIT  = 6;
    localparam int C_UF_BIT   = 4;
    localparam int C_CD_BIT   = 3;
    localparam int C_WP_BIT   = 2;

    typedef enum logic [1:0] {
        K_CAL,
        K_CTRL,
        K_STORE,
        K_VER
    } idx_kind_e;

    typedef enum logic [1:0] {
        CR_A = 2'd0,
        CR_B = 2'd1,
        CR_C = 2'd2,
        CR_D = 2'd3
    } ctrl_sel_e;

    function automatic logic [DW-1:0] to_bcd(input logic [DW-1:0] b);
        logic [DW-1:0] tens;
        logic [DW-1:0] ones;
        tens = b / 8'd10;
        ones = b % 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [DW-1:0] from_bcd(input logic [DW-1:0] d);
        return ({4'b0, d[7:4]} * 8'd10) + {4'b0, d[3:0]};
    endfunction

    function automatic logic [DW-1:0] field_limit(input logic [SEL_W-1:0] s);
        return (s == SEL_W'(4)) ? 8'd23 : 8'd59;
    endfunction

endpackage

// File: rtl/cmos_idx_decode.sv
module cmos_idx_decode
    import cmos_reg_pkg::*;
#(
    parameter logic [IW-1:0] VER_BASE = 8'hF0
) (
    input  logic [IW-1:0] idx,
    output idx_kind_e     kind,
    output ctrl_sel_e     csel
);
    logic [IW-1:0] rel;

    always_comb begin
        rel = idx - IW'(CTRL_BASE);
        csel = ctrl_sel_e'(rel[1:0]);
        if (idx < IW'(N_CAL))
            kind = K_CAL;
        else if (idx < IW'(CTRL_END))
            kind = K_CTRL;
        else if (idx < VER_BASE)
            kind = K_STORE;
        else
            kind = K_VER;
    end
endmodule

// File: rtl/cmos_cal_port.sv
module cmos_cal_port
    import cmos_reg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               bin_mode,
    input  logic [SEL_W-1:0]   sel,
    input  logic [DW-1:0]      wdata,
    input  logic [N_CAL*DW-1:0] cal_now,
    output logic [DW-1:0]      rd_val,
    output logic               cal_wr,
    output logic [SEL_W-1:0]   cal_sel,
    output logic [DW-1:0]      cal_wdata,
    output logic               tm_save
);
    logic [DW-1:0] fields [N_CAL];
    logic [DW-1:0] raw;
    logic          persist_fld;

    genvar g;
    generate
        for (g = 0; g < N_CAL; g++) begin : g_unpack
            assign fields[g] = cal_now[g*DW +: DW];
        end
    endgenerate

    always_comb begin
        raw = '0;
        for (int i = 0; i < N_CAL; i++)
            if (sel == SEL_W'(i)) raw = fields[i];
        rd_val = bin_mode ? raw : to_bcd(raw);
    end

    assign persist_fld = (sel == SEL_W'(0)) || (sel == SEL_W'(2)) || (sel == SEL_W'(4));
    assign cal_wr      = wr_en;
    assign cal_sel     = sel;
    assign cal_wdata   = bin_mode ? wdata : from_bcd(wdata);
    assign tm_save     = wr_en && persist_fld && (cal_wdata <= field_limit(sel));

    p_save_range_r4: assert property (@(posedge clk) disable iff (rst)
        tm_save |-> (cal_wr && (cal_wdata <= 8'd59)));
endmodule

// File: rtl/cmos_ctrl_bank.sv
module cmos_ctrl_bank
    import cmos_reg_pkg::*;
#(
    parameter logic [DW-1:0] A_INIT = 8'h26,
    parameter logic [DW-1:0] B_INIT = 8'h02,
    parameter logic [DW-1:0] D_INIT = 8'h80
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          wr_en,
    input  ctrl_sel_e     csel,
    input  logic [DW-1:0] wdata,
    input  logic          tick,
    input  logic          card_det_n,
    input  logic          wp_n,
    output logic [DW-1:0] rd_val,
    output logic          bin_mode,
    output logic          clr_log,
    output logic          led_cmd
);
    logic [DW-1:0] a_q, b_q, d_q;
    logic          uf_q, led_q, clr_q, ledp_q;
    logic [DW-1:0] c_view;
    logic          rd_c, wr_c;

    assign rd_c = rd_en && (csel == CR_C);
    assign wr_c = wr_en && (csel == CR_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= A_INIT;
            b_q    <= B_INIT;
            d_q    <= D_INIT;
            uf_q   <= 1'b0;
            led_q  <= 1'b0;
            clr_q  <= 1'b0;
            ledp_q <= 1'b0;
        end else begin
            clr_q  <= wr_c && wdata[C_CLR_BIT];
            ledp_q <= wr_c && (wdata[C_LED_BIT] != led_q);
            uf_q   <= tick || (uf_q && !rd_c);
            if (wr_c && (wdata[C_LED_BIT] != led_q))
                led_q <= ~led_q;
            if (wr_en && csel == CR_A) a_q <= wdata;
            if (wr_en && csel == CR_B) b_q <= (wdata & DW'(1 << B_MODE_BIT)) | B_INIT;
            if (wr_en && csel == CR_D) d_q <= wdata;
        end
    end

    always_comb begin
        c_view = '0;
        c_view[C_LED_BIT] = led_q;
        c_view[C_UF_BIT]  = uf_q || tick;
        c_view[C_CD_BIT]  = ~card_det_n;
        c_view[C_WP_BIT]  = ~wp_n;
        case (csel)
            CR_A:    rd_val = a_q;
            CR_B:    rd_val = b_q;
            CR_C:    rd_val = c_view;
            default: rd_val = d_q;
        endcase
    end

    assign bin_mode = b_q[B_MODE_BIT];
    assign clr_log  = clr_q;
    assign led_cmd  = ledp_q;

    p_uf_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_c && !tick) |=> !uf_q);
    p_uf_set_r6: assert property (@(posedge clk) disable iff (rst)
        tick |=> uf_q);
    p_clr_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        clr_log |-> $past(wr_c && wdata[C_CLR_BIT]));
    p_led_toggle_r9: assert property (@(posedge clk) disable iff (rst)
        led_cmd |-> (led_q != $past(led_q)));
    p_bmode_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && csel == CR_B) |=> (bin_mode == $past(wdata[B_MODE_BIT])));
endmodule

// File: rtl/cmos_reg_if.sv
module cmos_reg_if
    import cmos_reg_pkg::*;
#(
    parameter logic [IW-1:0] VER_BASE  = 8'hF0,
    parameter logic [IW-1:0] NV_OFFSET = 8'd2,
    parameter logic [DW-1:0] A_INIT    = 8'h26,
    parameter logic [DW-1:0] B_INIT    = 8'h02,
    parameter logic [DW-1:0] D_INIT    = 8'h80
) (
    input  logic                rst,
    input  logic                clk,
    input  logic                rd_stb,
    input  logic                wr_stb,
    input  logic [IW-1:0]       idx,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    input  logic                tick,
    input  logic                card_det_n,
    input  logic                wp_n,
    input  logic [N_CAL*DW-1:0] cal_now,
    output logic                cal_wr,
    output logic [SEL_W-1:0]    cal_sel,
    output logic [DW-1:0]       cal_wdata,
    output logic                tm_save,
    output logic                st_rd,
    output logic                st_wr,
    output logic [IW-1:0]       st_addr,
    output logic [DW-1:0]       st_wdata,
    input  logic [DW-1:0]       st_rdata,
    output logic [3:0]          ver_sel,
    input  logic [DW-1:0]       ver_byte,
    output logic                clr_log,
    output logic                led_cmd
);
    idx_kind_e     kind;
    ctrl_sel_e     csel;
    logic          bin_mode;
    logic [DW-1:0] cal_rd, ctrl_rd;

    cmos_idx_decode #(.VER_BASE(VER_BASE)) u_dec (
        .idx  (idx),
        .kind (kind),
        .csel (csel)
    );

    cmos_cal_port u_cal (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_stb && kind == K_CAL),
        .bin_mode  (bin_mode),
        .sel       (idx[SEL_W-1:0]),
        .wdata     (wdata),
        .cal_now   (cal_now),
        .rd_val    (cal_rd),
        .cal_wr    (cal_wr),
        .cal_sel   (cal_sel),
        .cal_wdata (cal_wdata),
        .tm_save   (tm_save)
    );

    cmos_ctrl_bank #(.A_INIT(A_INIT), .B_INIT(B_INIT), .D_INIT(D_INIT)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_stb && kind == K_CTRL),
        .wr_en      (wr_stb && kind == K_CTRL),
        .csel       (csel),
        .wdata      (wdata),
        .tick       (tick),
        .card_det_n (card_det_n),
        .wp_n       (wp_n),
        .rd_val     (ctrl_rd),
        .bin_mode   (bin_mode),
        .clr_log    (clr_log),
        .led_cmd    (led_cmd)
    );

    assign st_rd    = rd_stb && kind == K_STORE;
    assign st_wr    = wr_stb && kind == K_STORE;
    assign st_addr  = idx + NV_OFFSET;
    assign st_wdata = wdata;
    assign ver_sel  = idx[3:0];

    always_comb begin
        case (kind)
            K_CAL:   rdata = cal_rd;
            K_CTRL:  rdata = ctrl_rd;
            K_STORE: rdata = st_rdata;
            default: rdata = ver_byte;
        endcase
    end

    p_ver_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && idx >= VER_BASE) |-> !(st_wr || cal_wr || tm_save));
    p_store_addr_r11: assert property (@(posedge clk) disable iff (rst)
        (st_rd || st_wr) |-> (idx >= IW'(CTRL_END) && idx < VER_BASE));
endmodule

// File: tb/sim_cmos_reg_if.sv
module sim_cmos_reg_if;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_stb = 1'b0, wr_stb = 1'b0, tick = 1'b0;
    logic [7:0]  idx = '0, wdata = '0;
    logic        card_det_n = 1'b1, wp_n = 1'b1;
    logic [79:0] cal_now = '0;
    logic [7:0]  st_rdata = 8'hA7;
    logic [7:0]  rdata, cal_wdata, st_addr, st_wdata, ver_byte;
    logic [3:0]  cal_sel, ver_sel;
    logic        cal_wr, tm_save, st_rd, st_wr, clr_log, led_cmd;

    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;

    int m_a, m_b, m_d, m_uf, m_led, m_pclr, m_pled;

    always #(CLK_P/2) clk = ~clk;
    assign ver_byte = 8'h90 | {4'h0, ver_sel};

    cmos_reg_if u0 (
        .rst(rst), .clk(clk), .rd_stb(rd_stb), .wr_stb(wr_stb), .idx(idx),
        .wdata(wdata), .rdata(rdata), .tick(tick), .card_det_n(card_det_n),
        .wp_n(wp_n), .cal_now(cal_now), .cal_wr(cal_wr), .cal_sel(cal_sel),
        .cal_wdata(cal_wdata), .tm_save(tm_save), .st_rd(st_rd), .st_wr(st_wr),
        .st_addr(st_addr), .st_wdata(st_wdata), .st_rdata(st_rdata),
        .ver_sel(ver_sel), .ver_byte(ver_byte), .clr_log(clr_log), .led_cmd(led_cmd)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int bcd_of(input int v);
        return (((v / 10) << 4) | (v % 10)) & 255;
    endfunction

    function automatic int bin_of(input int w);
        return (((w >> 4) * 10) + (w & 15)) & 255;
    endfunction

    function automatic int cal_field(input int i);
        return int'(cal_now[i*8 +: 8]);
    endfunction

    // One bus cycle: drive, check against the reference model, then advance it.
    task automatic step(input bit rd, input bit wr, input int ix, input int wd, input bit tk);
        int exp_rd, binv, lim;
        bit mode, is_cal, is_st;
        @(negedge clk);
        rd_stb = rd; wr_stb = wr; idx = 8'(ix); wdata = 8'(wd); tick = tk;
        #2;
        mode   = ((m_b >> 2) & 1) == 1;
        is_cal = ix < 10;
        is_st  = ix >= 14 && ix < 240;
        // registered pulses from the previous cycle
        chk("R8 clr_log", int'(clr_log), m_pclr);
        chk("R9 led_cmd", int'(led_cmd), m_pled);
        if (rd) begin
            if (is_cal) begin
                exp_rd = mode ? cal_field(ix) : bcd_of(cal_field(ix));
                chk("R2 calendar read", int'(rdata), exp_rd);
            end else if (ix == 10) chk("R12 A read", int'(rdata), m_a);
            else if (ix == 11) chk("R5 B read", int'(rdata), m_b);
            else if (ix == 12) begin
                exp_rd = (m_led << 6) | ((m_uf | int'(tk)) << 4)
                       | (int'(!card_det_n) << 3) | (int'(!wp_n) << 2);
                chk("R6/R7 C read", int'(rdata), exp_rd);
            end else if (ix == 13) chk("R12 D read", int'(rdata), m_d);
            else if (is_st) chk("R11 storage read", int'(rdata), 8'hA7);
            else begin
                chk("R10 version read", int'(rdata), 8'h90 | (ix & 15));
                chk("R10 ver_sel", int'(ver_sel), ix & 15);
            end
        end
        chk("R3 cal_wr", int'(cal_wr), int'(wr && is_cal));
        binv = mode ? wd : bin_of(wd);
        lim  = (ix == 4) ? 23 : 59;
        chk("R4 tm_save", int'(tm_save),
            int'(wr && (ix == 0 || ix == 2 || ix == 4) && binv <= lim));
        if (wr && is_cal) begin
            chk("R3 cal_sel", int'(cal_sel), ix);
            chk("R3 cal_wdata", int'(cal_wdata), binv);
        end
        chk("R11 st_rd", int'(st_rd), int'(rd && is_st));
        chk("R11 st_wr", int'(st_wr), int'(wr && is_st));
        if ((rd || wr) && is_st) chk("R11 st_addr", int'(st_addr), (ix + 2) & 255);
        if (wr && is_st) chk("R11 st_wdata", int'(st_wdata), wd);
        @(posedge clk);
        #1;
        m_pclr = int'(wr && ix == 12 && ((wd >> 7) & 1) == 1);
        m_pled = 0;
        if (wr && ix == 12 && ((wd >> 6) & 1) != m_led) begin
            m_led  = 1 - m_led;
            m_pled = 1;
        end
        m_uf = int'(tk) | (m_uf & int'(!(rd && ix == 12)));
        if (wr && ix == 10) m_a = wd;
        if (wr && ix == 11) m_b = (wd & 4) | 2;
        if (wr && ix == 13) m_d = wd;
        rd_stb = 0; wr_stb = 0; tick = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_a = 8'h26; m_b = 8'h02; m_d = 8'h80; m_uf = 0; m_led = 0; m_pclr = 0; m_pled = 0;
        // sec, sec-alarm, min, min-alarm, hour, hour-alarm, dow, dom, month, year
        cal_now = {8'd99, 8'd12, 8'd31, 8'd3, 8'd0, 8'd23, 8'd0, 8'd7, 8'd0, 8'd45};
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        step(1, 0, 10, 0, 0);
        step(1, 0, 11, 0, 0);
        step(1, 0, 12, 0, 0);
        step(1, 0, 13, 0, 0);
        // R2 BCD reads
        step(1, 0, 0, 0, 0);
        step(1, 0, 4, 0, 0);
        step(1, 0, 9, 0, 0);
        // R5 select binary mode with junk bits
        step(0, 1, 11, 8'hFF, 0);
        step(1, 0, 11, 0, 0);
        step(1, 0, 0, 0, 0);
        step(1, 0, 7, 0, 0);
        // R3/R4 binary writes at range edges
        step(0, 1, 0, 60, 0);
        step(0, 1, 0, 59, 0);
        step(0, 1, 4, 23, 0);
        step(0, 1, 4, 24, 0);
        // back to BCD
        step(0, 1, 11, 8'hFB, 0);
        step(1, 0, 11, 0, 0);
        step(0, 1, 4, 8'h23, 0);
        step(0, 1, 4, 8'h24, 0);
        step(0, 1, 2, 8'h59, 0);
        step(0, 1, 2, 8'h60, 0);
        step(0, 1, 1, 8'h10, 0);
        step(0, 1, 9, 8'h42, 0);
        // R6 update flag
        step(0, 0, 12, 0, 1);
        step(1, 0, 12, 0, 0);
        step(1, 0, 12, 0, 0);
        step(1, 0, 12, 0, 1);
        step(1, 0, 12, 0, 0);
        step(1, 0, 12, 0, 0);
        // R7 card inputs
        card_det_n = 1'b0;
        step(1, 0, 12, 0, 0);
        wp_n = 1'b0; card_det_n = 1'b1;
        step(1, 0, 12, 0, 0);
        card_det_n = 1'b0;
        step(1, 0, 12, 0, 0);
        card_det_n = 1'b1; wp_n = 1'b1;
        // R8 clear-log pulse, R9 LED toggle
        step(0, 1, 12, 8'h80, 0);
        step(0, 0, 0, 0, 0);
        step(0, 1, 12, 8'h40, 0);
        step(1, 0, 12, 0, 0);
        step(0, 1, 12, 8'h40, 0);
        step(1, 0, 12, 0, 0);
        step(0, 1, 12, 8'hBF, 0);
        step(1, 0, 12, 0, 0);
        // R10 version window and ignored writes
        step(1, 0, 8'hF0, 0, 0);
        step(1, 0, 8'hF3, 0, 0);
        step(1, 0, 8'hFF, 0, 0);
        step(0, 1, 8'hF5, 8'hFF, 0);
        step(1, 0, 10, 0, 0);
        step(1, 0, 11, 0, 0);
        step(1, 0, 12, 0, 0);
        step(1, 0, 13, 0, 0);
        // R11 storage window edges
        step(1, 0, 14, 0, 0);
        step(0, 1, 14, 8'h3C, 0);
        step(1, 0, 8'hEF, 0, 0);
        step(0, 1, 8'hEF, 8'h5A, 0);
        step(0, 1, 13, 8'h11, 0);
        // R12 plain storage
        step(0, 1, 10, 8'hC5, 0);
        step(1, 0, 10, 0, 0);
        step(0, 1, 13, 8'h3E, 0);
        step(1, 0, 13, 0, 0);
        step(0, 0, 0, 0, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule